// File: doc/BRIEF.md
# Serial CRC-8 Packet Error Checker

This unit sits next to a byte-oriented two-wire serial bus controller. It folds every bus bit into an 8-bit CRC as the bit is shifted, most significant bit first. The polynomial comes from a programmable input, with x^8 + x^2 + x + 1 (0x07) as the usual setting. The CRC covers every byte of a message, so the address byte and its read/write bit are included along with each data byte. The running value returns to zero at every start condition.

To close a transmit message, software raises a send request after the last data byte has been loaded. At the end of that byte, the unit selects its own snapshot of the CRC as the next outgoing byte. To close a receive message, software raises a check request after the last data byte has arrived. The unit then treats the following byte as the checksum and folds its bits into the CRC. A non-zero remainder at that byte's boundary means a mismatch. A mismatch forces a NACK and sets a sticky error flag, and that flag can drive an interrupt line. When the unit is master receiver, the NACK is forced after the checksum byte whatever the comparison gives.

The controller supplies a bit strobe with its data bit, a byte-boundary pulse and a start-condition pulse. The byte-boundary pulse comes at least one cycle after the eighth bit strobe of the byte. Software supplies the request, clear and enable controls.

Top module: `pec_checker`

## Requirements
- R1: While `pec_en_i` is low, `crc_o` is held at 0, send and check requests are ignored (both pending flags stay 0), and `nack_o` stays 0.
- R2: After reset `crc_o` is 0. While enabled, each `bit_stb_i` cycle updates the CRC MSB-first as crc = {crc[6:0],0} XOR (poly_i if crc[7] XOR bit_i is 1, otherwise 0). The new value is visible the cycle after the strobe.
- R3: A `start_i` pulse while enabled sets `crc_o` to 0 on the next cycle, and takes priority over a bit strobe in the same cycle.
- R4: With a send request pending, the next byte boundary raises `tx_crc_sel_o`, and `tx_crc_byte_o` then holds the CRC value present at that boundary. Both stay unchanged until the following byte boundary.
- R5: A request sets its pending flag on the cycle after the request pulse. The flag clears on the cycle after the boundary that ends the checksum byte, and `tx_crc_sel_o` drops at the same moment.
- R6: With a check request pending, the byte after the next boundary is the checksum byte. If the CRC remainder is 0 at the end of that byte and `master_rx_i` is low, `nack_o` stays 0 and the error flag is not set.
- R7: If the remainder is non-zero at the end of the checksum byte, `nack_o` is 1 for exactly the one cycle after that boundary, and `err_o` is set.
- R8: When `master_rx_i` is 1 at the end of the checksum byte, `nack_o` pulses even on a match, and `err_o` is not set.
- R9: `err_o` stays set until an `err_clr_i` pulse, which clears it on the next cycle; a mismatch in the same cycle wins. `irq_o` equals `err_o` AND `irq_en_i`.
- R10: A send or check request is ignored while the other one (or itself) is pending; the two pending flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pec_en_i | input | 1 | Checking enable |
| poly_i | input | 8 | CRC polynomial, x^8 term implied |
| start_i | input | 1 | Start-condition pulse |
| bit_stb_i | input | 1 | One bus bit shifted this cycle |
| bit_i | input | 1 | Value of the shifted bit |
| byte_done_i | input | 1 | Byte-boundary pulse |
| send_req_i | input | 1 | Software request to append the CRC on transmit |
| chk_req_i | input | 1 | Software request to check the next received byte |
| master_rx_i | input | 1 | Unit is master receiver |
| err_clr_i | input | 1 | Clear the error flag |
| irq_en_i | input | 1 | Error interrupt enable |
| crc_o | output | 8 | Running CRC |
| send_pend_o | output | 1 | Send request pending |
| chk_pend_o | output | 1 | Check request pending |
| tx_crc_sel_o | output | 1 | Current outgoing byte is the CRC |
| tx_crc_byte_o | output | 8 | CRC byte to transmit |
| nack_o | output | 1 | Force NACK after the received checksum byte |
| err_o | output | 1 | Sticky CRC mismatch flag |
| irq_o | output | 1 | Error interrupt |

## Verification
The hardest case to reach from the ports is the boundary of the checksum byte itself. There the remainder must be exactly zero for a good frame, and the verdict lasts a single cycle. The bench computes the CRC of each frame on its own and then shifts that value (or a copy with one bit flipped) as the final byte. This drives the match, mismatch and master-receiver override paths, and each verdict is sampled on the one cycle it exists. Requests raised while another is armed, and frames with a different polynomial, cover the remaining paths.

// File: rtl/pec_pkg.sv
// Shared definitions for the packet error checker.
// Assumes: one CRC width across the block; the sequencer encodes its phase here.
package pec_pkg;
    localparam int unsigned PEC_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TX_ARM = 3'd1,
        PH_TX_CRC = 3'd2,
        PH_RX_ARM = 3'd3,
        PH_RX_CRC = 3'd4
    } pec_phase_e;
endpackage

// File: rtl/pec_crc_engine.sv
// Serial CRC engine: folds one bus bit per strobe, MSB first, with a
// programmable polynomial (top term implied).
// Assumes: start and strobe are single-cycle pulses; disable clears the value.
module pec_crc_engine #(
    parameter int unsigned W = pec_pkg::PEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         start_i,
    input  logic         bit_stb_i,
    input  logic         bit_i,
    input  logic [W-1:0] poly_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_step;
    logic         fb;

    // Next value of the CRC after one bit
    always_comb begin
        fb       = crc_q[W-1] ^ bit_i;
        crc_step = {crc_q[W-2:0], 1'b0} ^ (fb ? poly_i : '0);
    end

    // CRC register: cleared by reset, disable or start; advanced on strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || start_i) begin
            crc_q <= '0;
        end else if (bit_stb_i) begin
            crc_q <= crc_step;
        end
    end

    assign crc_o = crc_q;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> (crc_o == '0)); // R3
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (crc_o == '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !start_i && !bit_stb_i) |=> $stable(crc_o)); // R2
endmodule

// File: rtl/pec_sequencer.sv
// Request sequencer: arms a send or check request, turns the following byte
// into the checksum byte, snapshots the CRC for transmit and flags the end of
// a received checksum byte.
// Assumes: byte_done pulses at least one cycle after the last bit strobe.
module pec_sequencer #(
    parameter int unsigned W = pec_pkg::PEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         send_req_i,
    input  logic         chk_req_i,
    input  logic         byte_done_i,
    input  logic [W-1:0] crc_i,
    output logic         send_pend_o,
    output logic         chk_pend_o,
    output logic         tx_crc_sel_o,
    output logic [W-1:0] tx_crc_byte_o,
    output logic         rx_verdict_o,
    output logic         rx_bad_o
);
    import pec_pkg::*;

    pec_phase_e   ph_q, ph_d;
    logic [W-1:0] snap_q;

    // Phase transition rules
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (send_req_i)     ph_d = PH_TX_ARM;
                else if (chk_req_i) ph_d = PH_RX_ARM;
            end
            PH_TX_ARM: if (byte_done_i) ph_d = PH_TX_CRC;
            PH_TX_CRC: if (byte_done_i) ph_d = PH_IDLE;
            PH_RX_ARM: if (byte_done_i) ph_d = PH_RX_CRC;
            PH_RX_CRC: if (byte_done_i) ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
        if (!en_i) ph_d = PH_IDLE;
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Snapshot of the CRC taken at the boundary before the transmitted checksum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (en_i && ph_q == PH_TX_ARM && byte_done_i) begin
            snap_q <= crc_i;
        end
    end

    assign send_pend_o   = (ph_q == PH_TX_ARM) || (ph_q == PH_TX_CRC);
    assign chk_pend_o    = (ph_q == PH_RX_ARM) || (ph_q == PH_RX_CRC);
    assign tx_crc_sel_o  = (ph_q == PH_TX_CRC);
    assign tx_crc_byte_o = snap_q;
    assign rx_verdict_o  = en_i && (ph_q == PH_RX_CRC) && byte_done_i;
    assign rx_bad_o      = (crc_i != '0);

    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_pend_o && chk_pend_o)); // R10
    AST_TXBYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_crc_sel_o && !byte_done_i && en_i) |=> ($stable(tx_crc_byte_o) && tx_crc_sel_o)); // R4
    AST_SEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_crc_sel_o && byte_done_i) |=> (!tx_crc_sel_o && !send_pend_o)); // R5
endmodule

// File: rtl/pec_verdict.sv
// Verdict stage: forms the one-cycle NACK after a received checksum byte and
// keeps the sticky mismatch flag and its interrupt.
// Assumes: verdict is a single-cycle pulse at the checksum byte boundary.
module pec_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic verdict_i,
    input  logic bad_i,
    input  logic master_rx_i,
    input  logic err_clr_i,
    input  logic irq_en_i,
    output logic nack_o,
    output logic err_o,
    output logic irq_o
);
    logic nack_q;
    logic err_q;

    // One-cycle NACK: mismatch, or master receiver regardless of result
    always_ff @(posedge clk) begin
        if (!rst_n) nack_q <= 1'b0;
        else        nack_q <= verdict_i && (bad_i || master_rx_i);
    end

    // Sticky error flag: a mismatch wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (verdict_i && bad_i)   err_q <= 1'b1;
        else if (err_clr_i)            err_q <= 1'b0;
    end

    assign nack_o = nack_q;
    assign err_o  = err_q;
    assign irq_o  = err_q && irq_en_i;

    AST_NACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |-> $past(verdict_i)); // R7
    AST_NACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_o && !verdict_i) |=> !nack_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o); // R9
    AST_MASTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_i && master_rx_i) |=> nack_o); // R8
endmodule

// File: rtl/pec_checker.sv
// Top of the packet error checker: serial CRC engine, request sequencer and
// verdict stage beside a byte-oriented serial bus controller.
// Assumes: the controller supplies bit, byte-boundary and start pulses.
module pec_checker #(
    parameter int unsigned W = pec_pkg::PEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pec_en_i,
    input  logic [W-1:0] poly_i,
    input  logic         start_i,
    input  logic         bit_stb_i,
    input  logic         bit_i,
    input  logic         byte_done_i,
    input  logic         send_req_i,
    input  logic         chk_req_i,
    input  logic         master_rx_i,
    input  logic         err_clr_i,
    input  logic         irq_en_i,
    output logic [W-1:0] crc_o,
    output logic         send_pend_o,
    output logic         chk_pend_o,
    output logic         tx_crc_sel_o,
    output logic [W-1:0] tx_crc_byte_o,
    output logic         nack_o,
    output logic         err_o,
    output logic         irq_o
);
    logic [W-1:0] crc_w;
    logic         verdict_w;
    logic         bad_w;

    pec_crc_engine #(.W(W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (pec_en_i),
        .start_i   (start_i),
        .bit_stb_i (bit_stb_i),
        .bit_i     (bit_i),
        .poly_i    (poly_i),
        .crc_o     (crc_w)
    );

    pec_sequencer #(.W(W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (pec_en_i),
        .send_req_i    (send_req_i),
        .chk_req_i     (chk_req_i),
        .byte_done_i   (byte_done_i),
        .crc_i         (crc_w),
        .send_pend_o   (send_pend_o),
        .chk_pend_o    (chk_pend_o),
        .tx_crc_sel_o  (tx_crc_sel_o),
        .tx_crc_byte_o (tx_crc_byte_o),
        .rx_verdict_o  (verdict_w),
        .rx_bad_o      (bad_w)
    );

    pec_verdict u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .verdict_i   (verdict_w),
        .bad_i       (bad_w),
        .master_rx_i (master_rx_i),
        .err_clr_i   (err_clr_i),
        .irq_en_i    (irq_en_i),
        .nack_o      (nack_o),
        .err_o       (err_o),
        .irq_o       (irq_o)
    );

    assign crc_o = crc_w;

    AST_DISABLED_NO_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pec_en_i) |=> !nack_o); // R1
    AST_DISABLED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!pec_en_i) |=> (!send_pend_o && !chk_pend_o)); // R1
endmodule

// File: tb/pec_checker_tb.sv
`timescale 1ns/1ps
module pec_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] poly = 8'h07;
    logic       start = 1'b0, bstb = 1'b0, bval = 1'b0, bdone = 1'b0;
    logic       sreq = 1'b0, creq = 1'b0, mrx = 1'b0, eclr = 1'b0, ien = 1'b0;
    logic [7:0] crc, txb;
    logic       spend, cpend, sel, nack, err, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] m_crc = 8'h00;

    typedef struct {
        string      tag;
        string      what;
        logic [7:0] exp;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pec_checker u_dut (
        .clk(clk), .rst_n(rst_n), .pec_en_i(en), .poly_i(poly),
        .start_i(start), .bit_stb_i(bstb), .bit_i(bval), .byte_done_i(bdone),
        .send_req_i(sreq), .chk_req_i(creq), .master_rx_i(mrx),
        .err_clr_i(eclr), .irq_en_i(ien), .crc_o(crc),
        .send_pend_o(spend), .chk_pend_o(cpend), .tx_crc_sel_o(sel),
        .tx_crc_byte_o(txb), .nack_o(nack), .err_o(err), .irq_o(irq)
    );

    // Reference CRC step taken from the requirement text
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic b,
                                            input logic [7:0] p);
        logic f;
        f = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (f ? p : 8'h00);
    endfunction

    function automatic logic [7:0] observe(input string what);
        case (what)
            "crc":   return crc;
            "txb":   return txb;
            "sel":   return {7'd0, sel};
            "spend": return {7'd0, spend};
            "cpend": return {7'd0, cpend};
            "nack":  return {7'd0, nack};
            "err":   return {7'd0, err};
            "irq":   return {7'd0, irq};
            default: return 8'hxx;
        endcase
    endfunction

    // Monitor: pops expected items 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] a;
                e = q.pop_front();
                a = observe(e.what);
                checks++;
                if (a !== e.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", e.tag, e.what, a, e.exp);
                end
            end
        end
    end

    // Driver-side scoreboard push
    task automatic expect_v(input string tag, input string what, input logic [7:0] v);
        exp_t e;
        e.tag = tag; e.what = what; e.exp = v;
        q.push_back(e);
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    // Shift one byte MSB first then give a boundary; model follows when enabled
    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bstb = 1'b1; bval = b[i];
            if (en) m_crc = ref_step(m_crc, b[i], poly);
        end
        @(negedge clk); bstb = 1'b0; bdone = 1'b1;
        @(negedge clk); bdone = 1'b0;
    endtask

    task automatic do_start();
        pulse(start);
        m_crc = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_v("R2", "crc", 8'h00);
        expect_v("R5", "spend", 8'h00);
        expect_v("R7", "nack", 8'h00);
        expect_v("R9", "err", 8'h00);
        settle();
        @(negedge clk); rst_n = 1'b1; en = 1'b1; ien = 1'b1;

        // Transmit frame with CRC append
        do_start();
        put_byte(8'hA4);
        expect_v("R2", "crc", m_crc); settle();
        put_byte(8'h12);
        put_byte(8'hFF);
        expect_v("R2", "crc", m_crc); settle();
        pulse(sreq);
        expect_v("R5", "spend", 8'h01);
        expect_v("R4", "sel", 8'h00); settle();
        put_byte(8'h3C);
        begin
            logic [7:0] snap;
            snap = m_crc;
            expect_v("R4", "sel", 8'h01);
            expect_v("R4", "txb", snap); settle();
            put_byte(snap);
            expect_v("R2", "crc", 8'h00);
            expect_v("R5", "sel", 8'h00);
            expect_v("R5", "spend", 8'h00);
            expect_v("R4", "txb", snap); settle();
        end

        // Start clears, and wins over a simultaneous strobe
        put_byte(8'h5A);
        @(negedge clk); start = 1'b1; bstb = 1'b1; bval = 1'b1;
        @(negedge clk); start = 1'b0; bstb = 1'b0; m_crc = 8'h00;
        expect_v("R3", "crc", 8'h00); settle();

        // Receive frame, good checksum
        put_byte(8'hA5);
        put_byte(8'h01);
        pulse(creq);
        expect_v("R5", "cpend", 8'h01); settle();
        pulse(sreq);
        expect_v("R10", "spend", 8'h00);
        expect_v("R10", "cpend", 8'h01); settle();
        put_byte(8'h77);
        put_byte(m_crc);
        expect_v("R6", "nack", 8'h00);
        expect_v("R6", "err", 8'h00);
        expect_v("R5", "cpend", 8'h00); settle();

        // Receive frame, bad checksum
        do_start();
        put_byte(8'hA5);
        pulse(creq);
        put_byte(8'h9E);
        put_byte(m_crc ^ 8'h01);
        expect_v("R7", "nack", 8'h01);
        expect_v("R7", "err", 8'h01);
        expect_v("R9", "irq", 8'h01); settle();
        @(negedge clk);
        expect_v("R7", "nack", 8'h00); settle();
        @(negedge clk); ien = 1'b0;
        expect_v("R9", "irq", 8'h00); settle();
        do_start();
        put_byte(8'h10);
        expect_v("R9", "err", 8'h01); settle();
        pulse(eclr);
        expect_v("R9", "err", 8'h00); settle();

        // Master receiver: NACK forced on a match, no error
        mrx = 1'b1;
        do_start();
        put_byte(8'hA1);
        pulse(creq);
        put_byte(8'h44);
        put_byte(m_crc);
        expect_v("R8", "nack", 8'h01);
        expect_v("R8", "err", 8'h00); settle();
        mrx = 1'b0;

        // Other polynomial
        poly = 8'h31;
        do_start();
        put_byte(8'hC3);
        put_byte(8'h81);
        expect_v("R2", "crc", m_crc); settle();
        poly = 8'h07;

        // Disabled: CRC held, requests ignored
        @(negedge clk); en = 1'b0; m_crc = 8'h00;
        put_byte(8'hE7);
        expect_v("R1", "crc", 8'h00); settle();
        pulse(creq);
        expect_v("R1", "cpend", 8'h00); settle();
        pulse(sreq);
        expect_v("R1", "spend", 8'h00); settle();
        put_byte(8'h00);
        expect_v("R1", "nack", 8'h00); settle();

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule